// File: doc/BRIEF.md
# Turbo CPU Time-Slot Scheduler

This block decides, slot by slot, whether the processor may complete a memory cycle in a fast memory system that divides every 1 MHz period into a fixed number of time slots (48 by default, 64 in the wider build). Each slot can serve one internal memory byte. The processor's speed is picked by a 4-bit speed index that selects a rate in MHz. The scheduler hands that many of the period's slots to the processor, spread as evenly as it can through an accumulator that adds the rate every slot and wraps at the slot count.

The video controller always takes any slot it asks for. The bus-available signal still governs the processor. When the compatible bad-line timing is in force, a low bus-available halts the processor. When that timing is switched off, the processor may carry on through a low bus-available, but only for internal accesses. Accesses that leave the chip go through an external bridge at the 1 MHz rate, once per period, and only while bus-available is high. A processor slot lost to video or to the bus is owed, not dropped, and is paid back in the next slot the processor may use.

Every output is registered: the decision for the slot whose inputs are sampled at clock edge k appears on the outputs right after edge k.

Top module: `turbo_slot_sched`

## Requirements
- R1: A synchronous active-high reset clears the slot counter, the accumulator and the owed-slot count. All three outputs are low in the cycle after any reset edge.
- R2: With SLOTS=48, speed index values 0 to 15 select 1, 2, 3, 4, 5, 6, 8, 10, 12, 14, 16, 20, 24, 32, 40 and 48 MHz. With no video requests, bus-available high and internal accesses, any 48 consecutive slots after reset carry exactly that many cpu_ce pulses.
- R3: With SLOTS=64, speed index values 0 to 15 select 1, 2, 3, 4, 6, 8, 10, 12, 14, 16, 20, 24, 32, 40, 48 and 64 MHz. Under the same conditions as R2, any 64 consecutive slots carry exactly that many pulses.
- R4: vid_gnt follows vid_req one cycle later. cpu_ce is never high in a cycle where vid_gnt is high, whatever the bad-line setting.
- R5: While badline_off is 0, a slot sampled with ba low never yields cpu_ce.
- R6: While badline_off is 1, a slot sampled with ba low still yields cpu_ce for an internal access (cpu_ext=0) at the selected rate.
- R7: An external access (cpu_ext=1) is granted only in the bridge slot, which is slot SLOTS-1 of each period counted from 0 after reset, and only if ba is high. Its grant raises ext_req together with cpu_ce. A low ba blocks it even while badline_off is 1.
- R8: A slot credit that cannot be used is kept and spent in the next usable slot. At most SLOTS credits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| speed_idx | input | 4 | Processor speed index |
| badline_off | input | 1 | 1 lets internal accesses run through low bus-available |
| ba | input | 1 | Bus available, low when video owns the bus |
| vid_req | input | 1 | Video controller requests this slot |
| cpu_ext | input | 1 | Pending processor access targets the external bus |
| cpu_ce | output | 1 | Processor completes a cycle in this slot |
| vid_gnt | output | 1 | Slot granted to the video controller |
| ext_req | output | 1 | Request to the external bridge for this slot |

## Verification
The hardest state to reach from the ports is a large owed-slot backlog that is still not paid out. Building one needs a long run of blocked slots, and then an exact release pattern to see the burst. The stimulus holds vid_req high for several full periods at the slowest speed. It then drops vid_req and looks at the very next output slot on both slot-count builds. It also mixes in long external-access stretches where only the bridge slot can spend a credit, so the count reaches its cap. A random phase then drives every input together, and a behavioural model compares the outputs on every clock.

// File: rtl/turbo_sched_pkg.sv
package turbo_sched_pkg;

  localparam int unsigned MHZ_W = 7;

  // Rate table for the 48-slot build
  function automatic logic [MHZ_W-1:0] mhz_base(input logic [3:0] idx);
    case (idx)
      4'd0:  mhz_base = 7'd1;
      4'd1:  mhz_base = 7'd2;
      4'd2:  mhz_base = 7'd3;
      4'd3:  mhz_base = 7'd4;
      4'd4:  mhz_base = 7'd5;
      4'd5:  mhz_base = 7'd6;
      4'd6:  mhz_base = 7'd8;
      4'd7:  mhz_base = 7'd10;
      4'd8:  mhz_base = 7'd12;
      4'd9:  mhz_base = 7'd14;
      4'd10: mhz_base = 7'd16;
      4'd11: mhz_base = 7'd20;
      4'd12: mhz_base = 7'd24;
      4'd13: mhz_base = 7'd32;
      4'd14: mhz_base = 7'd40;
      default: mhz_base = 7'd48;
    endcase
  endfunction

  // Rate table for the 64-slot build
  function automatic logic [MHZ_W-1:0] mhz_wide(input logic [3:0] idx);
    case (idx)
      4'd0:  mhz_wide = 7'd1;
      4'd1:  mhz_wide = 7'd2;
      4'd2:  mhz_wide = 7'd3;
      4'd3:  mhz_wide = 7'd4;
      4'd4:  mhz_wide = 7'd6;
      4'd5:  mhz_wide = 7'd8;
      4'd6:  mhz_wide = 7'd10;
      4'd7:  mhz_wide = 7'd12;
      4'd8:  mhz_wide = 7'd14;
      4'd9:  mhz_wide = 7'd16;
      4'd10: mhz_wide = 7'd20;
      4'd11: mhz_wide = 7'd24;
      4'd12: mhz_wide = 7'd32;
      4'd13: mhz_wide = 7'd40;
      4'd14: mhz_wide = 7'd48;
      default: mhz_wide = 7'd64;
    endcase
  endfunction

endpackage

// File: rtl/turbo_slot_phase.sv
// Slot position within the 1 MHz period and the rate accumulator.
module turbo_slot_phase #(
  parameter int unsigned SLOTS = 48,
  parameter int unsigned MW    = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] mhz,
  output logic          earn,
  output logic          bridge_slot
);
  localparam int unsigned SW = $clog2(SLOTS);
  localparam int unsigned AW = $clog2(2 * SLOTS);

  logic [SW-1:0] slot_q;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] sum;
  logic [AW-1:0] acc_d;

  always_comb begin
    sum   = acc_q + AW'(mhz);
    earn  = (sum >= AW'(SLOTS));
    acc_d = earn ? (sum - AW'(SLOTS)) : sum;
  end

  assign bridge_slot = (slot_q == SW'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      acc_q  <= '0;
    end else begin
      slot_q <= bridge_slot ? '0 : slot_q + 1'b1;
      acc_q  <= acc_d;
    end
  end

endmodule

// File: rtl/turbo_credit_arb.sv
// Owed-slot count and per-slot processor grant.
module turbo_credit_arb #(
  parameter int unsigned SLOTS = 48,
  parameter int unsigned MW    = $clog2(SLOTS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic earn,
  input  logic bridge_slot,
  input  logic vid_req,
  input  logic ba,
  input  logic badline_off,
  input  logic cpu_ext,
  output logic grant
);
  logic [MW-1:0] owed_q;
  logic [MW:0]   avail;
  logic [MW:0]   remain;
  logic [MW-1:0] owed_d;
  logic          path_ok;

  always_comb begin
    avail = {1'b0, owed_q} + {{MW{1'b0}}, earn};
    if (vid_req)
      path_ok = 1'b0;
    else if (cpu_ext)
      path_ok = ba && bridge_slot;
    else
      path_ok = ba || badline_off;
    grant  = (avail != '0) && path_ok;
    remain = avail - {{MW{1'b0}}, grant};
    owed_d = (remain > (MW+1)'(SLOTS)) ? MW'(SLOTS) : remain[MW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) owed_q <= '0;
    else     owed_q <= owed_d;
  end

endmodule

// File: rtl/turbo_slot_sched.sv
module turbo_slot_sched #(
  parameter int unsigned SLOTS = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] speed_idx,
  input  logic       badline_off,
  input  logic       ba,
  input  logic       vid_req,
  input  logic       cpu_ext,
  output logic       cpu_ce,
  output logic       vid_gnt,
  output logic       ext_req
);
  import turbo_sched_pkg::*;

  localparam int unsigned MW = $clog2(SLOTS + 1);

  logic [MW-1:0] mhz_sel;
  logic          earn;
  logic          bridge_slot;
  logic          grant;

  generate
    if (SLOTS == 64) begin : g_wide
      assign mhz_sel = MW'(mhz_wide(speed_idx));
    end else begin : g_base
      assign mhz_sel = MW'(mhz_base(speed_idx));
    end
  endgenerate

  turbo_slot_phase #(.SLOTS(SLOTS), .MW(MW)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .mhz         (mhz_sel),
    .earn        (earn),
    .bridge_slot (bridge_slot)
  );

  turbo_credit_arb #(.SLOTS(SLOTS), .MW(MW)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .earn        (earn),
    .bridge_slot (bridge_slot),
    .vid_req     (vid_req),
    .ba          (ba),
    .badline_off (badline_off),
    .cpu_ext     (cpu_ext),
    .grant       (grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ce  <= 1'b0;
      vid_gnt <= 1'b0;
      ext_req <= 1'b0;
    end else begin
      cpu_ce  <= grant;
      vid_gnt <= vid_req;
      ext_req <= grant && cpu_ext;
    end
  end

endmodule

// File: rtl/turbo_slot_sched_chk.sv
module turbo_slot_sched_chk #(
  parameter int unsigned SLOTS = 48
) (
  input logic clk,
  input logic rst,
  input logic ba,
  input logic badline_off,
  input logic vid_req,
  input logic cpu_ext,
  input logic cpu_ce,
  input logic vid_gnt,
  input logic ext_req
);
  localparam int unsigned GW = $clog2(SLOTS + 1) + 1;

  logic          rst_d;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)
      gap_q <= '0;
    else if (ext_req)
      gap_q <= GW'(1);
    else if (gap_q < GW'(SLOTS))
      gap_q <= gap_q + 1'b1;
  end

  // R1
  always_ff @(negedge clk) begin
    if (rst_d) begin
      reset_quiet_chk: assert (!cpu_ce && !vid_gnt && !ext_req);
    end
  end

  // R4
  video_excl_chk: assert property (@(posedge clk) disable iff (rst)
    vid_gnt |-> !cpu_ce);

  // R4
  video_follow_chk: assert property (@(posedge clk) disable iff (rst)
    vid_req |=> vid_gnt);

  // R5
  badline_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (!badline_off && !ba) |=> !cpu_ce);

  // R7
  ext_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba || !cpu_ext) |=> !ext_req);

  // R7
  ext_with_ce_chk: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> cpu_ce);

  // R7
  ext_rate_chk: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> (gap_q >= GW'(SLOTS - 1)));

endmodule

bind turbo_slot_sched turbo_slot_sched_chk #(.SLOTS(SLOTS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ba          (ba),
  .badline_off (badline_off),
  .vid_req     (vid_req),
  .cpu_ext     (cpu_ext),
  .cpu_ce      (cpu_ce),
  .vid_gnt     (vid_gnt),
  .ext_req     (ext_req)
);

// File: tb/turbo_slot_sched_bench.sv
`timescale 1ns/1ps
module turbo_slot_sched_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] speed_idx = 4'd0;
  logic       badline_off = 1'b0;
  logic       ba = 1'b1;
  logic       vid_req = 1'b0;
  logic       cpu_ext = 1'b0;
  logic       ce_n, vid_n, ext_n;
  logic       ce_w, vid_w, ext_w;

  always #2 clk = ~clk;

  turbo_slot_sched #(.SLOTS(48)) u_turbo_slot_sched (
    .clk(clk), .rst(rst), .speed_idx(speed_idx), .badline_off(badline_off),
    .ba(ba), .vid_req(vid_req), .cpu_ext(cpu_ext),
    .cpu_ce(ce_n), .vid_gnt(vid_n), .ext_req(ext_n));

  turbo_slot_sched #(.SLOTS(64)) u_turbo_slot_sched_wide (
    .clk(clk), .rst(rst), .speed_idx(speed_idx), .badline_off(badline_off),
    .ba(ba), .vid_req(vid_req), .cpu_ext(cpu_ext),
    .cpu_ce(ce_w), .vid_gnt(vid_w), .ext_req(ext_w));

  int rate_n [16] = '{1,2,3,4,5,6,8,10,12,14,16,20,24,32,40,48};
  int rate_w [16] = '{1,2,3,4,6,8,10,12,14,16,20,24,32,40,48,64};

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R1 reset";
  bit    model_live = 0;

  // behavioural reference, index 0 = 48 slots, 1 = 64 slots
  int acc [2];
  int owed [2];
  int pos [2];
  bit x_ce [2];
  bit x_ext [2];
  bit x_vid;
  int ce_cnt [2];
  int ext_cnt [2];

  always @(posedge clk) begin
    model_live <= 1;
    for (int v = 0; v < 2; v++) begin
      int s, m, avail;
      bit earn, bridge, ok, g;
      s = (v == 0) ? 48 : 64;
      if (rst) begin
        acc[v] = 0; owed[v] = 0; pos[v] = 0;
        x_ce[v] = 0; x_ext[v] = 0;
      end else begin
        m = (v == 0) ? rate_n[speed_idx] : rate_w[speed_idx];
        acc[v] = acc[v] + m;
        earn = (acc[v] >= s);
        if (earn) acc[v] = acc[v] - s;
        bridge = (pos[v] == s - 1);
        pos[v] = (pos[v] + 1) % s;
        avail = owed[v] + (earn ? 1 : 0);
        if (vid_req) ok = 0;
        else if (cpu_ext) ok = ba && bridge;
        else ok = ba || badline_off;
        g = (avail > 0) && ok;
        owed[v] = avail - (g ? 1 : 0);
        if (owed[v] > s) owed[v] = s;
        x_ce[v] = g;
        x_ext[v] = g && cpu_ext;
      end
    end
    x_vid = rst ? 1'b0 : vid_req;
  end

  always @(negedge clk) begin
    if (model_live) begin
      vectors++;
      if ({ce_n, ext_n, vid_n, ce_w, ext_w, vid_w} !==
          {x_ce[0], x_ext[0], x_vid, x_ce[1], x_ext[1], x_vid}) begin
        miscompares++;
        $display("FAIL %s: ce/ext/vid 48=%b%b%b 64=%b%b%b, expected 48=%b%b%b 64=%b%b%b",
                 tag, ce_n, ext_n, vid_n, ce_w, ext_w, vid_w,
                 x_ce[0], x_ext[0], x_vid, x_ce[1], x_ext[1], x_vid);
      end
      if (ce_n) ce_cnt[0]++;
      if (ce_w) ce_cnt[1]++;
      if (ext_n) ext_cnt[0]++;
      if (ext_w) ext_cnt[1]++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // counts output slots for w slots of the inputs currently applied
  task automatic measure(input int w);
    @(posedge clk); #1;
    ce_cnt = '{0, 0}; ext_cnt = '{0, 0};
    repeat (w - 1) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic set_in(input int idx, input bit blo, input bit b, input bit vr, input bit ex);
    speed_idx = 4'(idx); badline_off = blo; ba = b; vid_req = vr; cpu_ext = ex;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs low during reset
    check({ce_n, vid_n, ext_n, ce_w, vid_w, ext_w} == 6'b0, "R1 reset outputs",
          {ce_n, vid_n, ext_n, ce_w, vid_w, ext_w}, 0);

    // R2 and R3: rate per window of 192 slots (4 periods of 48, 3 of 64)
    for (int i = 0; i < 16; i++) begin
      tag = "R2/R3 rate";
      do_reset();
      set_in(i, 0, 1, 0, 0);
      measure(192);
      check(ce_cnt[0] == 4 * rate_n[i], "R2 rate 48-slot", ce_cnt[0], 4 * rate_n[i]);
      check(ce_cnt[1] == 3 * rate_w[i], "R3 rate 64-slot", ce_cnt[1], 3 * rate_w[i]);
    end

    // R5: bad-line timing on, ba low halts
    tag = "R5 halt";
    do_reset();
    set_in(15, 0, 0, 0, 0);
    measure(192);
    check(ce_cnt[0] + ce_cnt[1] == 0, "R5 ba low halts", ce_cnt[0] + ce_cnt[1], 0);

    // R6: bad-line timing off, internal keeps running
    tag = "R6 run";
    do_reset();
    set_in(5, 1, 0, 0, 0);
    measure(192);
    check(ce_cnt[0] == 24, "R6 internal 48-slot", ce_cnt[0], 24);
    check(ce_cnt[1] == 24, "R6 internal 64-slot", ce_cnt[1], 24);

    // R7: external blocked by ba low even with bad-lines off
    tag = "R7 ext";
    do_reset();
    set_in(15, 1, 0, 0, 1);
    measure(192);
    check(ext_cnt[0] + ext_cnt[1] == 0, "R7 ext blocked", ext_cnt[0] + ext_cnt[1], 0);
    do_reset();
    set_in(15, 0, 1, 0, 1);
    measure(192);
    check(ext_cnt[0] == 4, "R7 ext once per period 48", ext_cnt[0], 4);
    check(ext_cnt[1] == 3, "R7 ext once per period 64", ext_cnt[1], 3);

    // R4 and R8: video blocks, credits owed then repaid
    tag = "R4/R8 defer";
    do_reset();
    set_in(0, 1, 1, 1, 0);
    measure(192);
    check(ce_cnt[0] + ce_cnt[1] == 0, "R4 video wins", ce_cnt[0] + ce_cnt[1], 0);
    vid_req = 1'b0;
    @(posedge clk); @(negedge clk);
    check(ce_n == 1'b1, "R8 owed slot paid 48", ce_n, 1);
    check(ce_w == 1'b1, "R8 owed slot paid 64", ce_w, 1);
    #1;
    measure(3);
    check(ce_cnt[0] == 3, "R8 backlog burst 48", ce_cnt[0], 3);
    check(ce_cnt[1] == 2, "R8 backlog burst 64", ce_cnt[1], 2);

    // R8 cap: long external stretch saturates the owed count
    tag = "R8 cap";
    do_reset();
    set_in(15, 0, 1, 0, 1);
    repeat (400) @(posedge clk);
    #1 cpu_ext = 1'b0; speed_idx = 4'd0;
    measure(48);
    check(ce_cnt[0] == 48, "R8 capped backlog 48", ce_cnt[0], 48);

    // mixed random traffic against the model
    tag = "R4 R5 R6 R7 R8 mixed";
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      set_in(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
             ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0),
             ($urandom_range(0, 3) == 0));
      @(posedge clk); #1;
    end

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule